// File: doc/BRIEF.md
# Floating-Point Exception Trap Controller

This block sits beside a floating-point unit. For each completing instruction it takes the exception flags the unit raised and decides three things: what to record, whether to raise an arithmetic trap, and whether the destination takes the IEEE non-trapping default in place of a trap. It does not compute the arithmetic or the default values. It only drives the selects that pick them.

The block holds a control/status register with a write port. Sticky status bits in this register gather every exception seen since the last write. Per-exception disable bits let software-completed instructions finish with default results. Two further bits control underflow-to-zero and treating denormal inputs as zero. When a trap is taken, the exception summary register latches the cause and keeps it until it is acknowledged.

Flag and field encoding used throughout: exception index 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact, 5 denormal input. The register word is laid out as follows:
- bits [5:0] are the sticky status bits, in exception index order.
- bits [10:6] are the disable bits for exceptions 0 to 4.
- bit 11 is underflow-to-zero.
- bit 12 is denormals-as-zero.

Top module: `fp_exc_trap_ctl`

## Requirements
- R1: On every cycle with `instValid` high, each set bit of `excFlags` sets the matching status bit in `csrValue[5:0]`, whether or not that exception traps.
- R2: Status bits never clear except through a register write. When a write and a valid instruction coincide, the written word is loaded first and the instruction's flags are OR-ed into its status field.
- R3: An exception i in 0..4 whose flag and `instTrapEn[i]` are both set traps, unless it is suppressed (R4). `trapReq` is high in the same cycle as `instValid`. On the next clock edge `excSummary` holds the trapping bits and `summaryValid` is 1.
- R4: An exception is suppressed only when its disable bit (`csrValue[6+i]`) is set and `swComp` is high. A disable bit without `swComp` has no effect. When suppressed exceptions exist and nothing traps, `defaultSel` is high and `trapReq` is low.
- R5: A denormal-input flag (bit 5) traps whenever `csrValue[12]` is 0, independent of `instTrapEn` and `swComp`. When `csrValue[12]` is 1 it never traps.
- R6: When an input-operand trap (R5) and result traps occur together, only the input trap is reported: `excSummary` is exactly `6'b100000`.
- R7: `excSummary` and `summaryValid` hold until `summaryAck`. An ack clears both to zero on the next edge. A trap in the same cycle as an ack loads the new summary instead.
- R8: `flushZero` is high in a valid cycle with the underflow flag set and no trap, so the destination receives +0 rather than a denormal.
- R9: `cfgError` is high whenever the underflow disable bit (`csrValue[9]`) is set while underflow-to-zero (`csrValue[11]`) is clear.
- R10: With `instValid` low, `excFlags` has no effect: `trapReq`, `defaultSel` and `flushZero` stay low and the status bits do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instValid | input | 1 | Completing instruction strobe |
| excFlags | input | 6 | Exception flags of the completing instruction |
| instTrapEn | input | 5 | Instruction trap enables for exceptions 0..4 |
| swComp | input | 1 | Software-completion qualifier of the instruction |
| csrWrEn | input | 1 | Control/status register write strobe |
| csrWrData | input | 13 | Control/status register write data |
| summaryAck | input | 1 | Acknowledge and clear the exception summary |
| csrValue | output | 13 | Current control/status register contents |
| excSummary | output | 6 | Latched exception summary of the last trap |
| summaryValid | output | 1 | Summary holds an unacknowledged trap |
| trapReq | output | 1 | Arithmetic trap request, one cycle with instValid |
| defaultSel | output | 1 | Select the non-trapping default result |
| flushZero | output | 1 | Select +0 for an untrapped underflow |
| cfgError | output | 1 | Underflow disable set without underflow-to-zero |

## Verification
The hardest situation to reach is the full interaction between instruction enables, disable bits, the completion qualifier and the denormal control, with the priority rule deciding which bits reach the summary. The stimulus reaches it with a sweep over every flag pattern, every enable pattern, both qualifier values and both denormal settings. A freshly written register precedes each instruction, and the disable bits rotate arithmetically with the loop indices. The other hard cases are a register write in the same cycle as an exception, and an acknowledge in the same cycle as a new trap. Directed sequences drive exactly those coincidences.

// File: rtl/fp_exc_pkg.sv
`timescale 1ns/1ps
package fp_exc_pkg;
  localparam int EXC_NUM  = 6;                    // all exception kinds
  localparam int RES_NUM  = EXC_NUM - 1;          // result-class exceptions
  localparam int IDX_UF   = 3;                    // underflow flag index
  localparam int IDX_DEN  = EXC_NUM - 1;          // denormal input flag index
  localparam int DIS_LO   = EXC_NUM;              // first disable bit
  localparam int UNDZ_POS = DIS_LO + RES_NUM;     // underflow-to-zero bit
  localparam int DNZ_POS  = UNDZ_POS + 1;         // denormals-as-zero bit
  localparam int CSR_W    = DNZ_POS + 1;

  typedef struct packed {
    logic csrWrite;   // load written word
    logic excRecord;  // OR flags into status
    logic sumLoad;    // latch trap summary
    logic sumClear;   // acknowledge summary
  } ctlStrobes_t;
endpackage

// File: rtl/fp_exc_ctrl.sv
`timescale 1ns/1ps
module fp_exc_ctrl
  import fp_exc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instValid,
  input  logic [EXC_NUM-1:0] excFlags,
  input  logic [RES_NUM-1:0] instTrapEn,
  input  logic               swComp,
  input  logic               csrWrEn,
  input  logic               summaryAck,
  input  logic [RES_NUM-1:0] disBits,
  input  logic               undzBit,
  input  logic               dnzBit,
  output logic               trapReq,
  output logic               defaultSel,
  output logic               flushZero,
  output logic               cfgError,
  output logic [EXC_NUM-1:0] trapBits,
  output ctlStrobes_t        strobes
);
  logic [RES_NUM-1:0] wanted, suppressed, resTrap;
  logic inputTrap, resultTrap;

  for (genvar i = 0; i < RES_NUM; i++) begin : g_res
    assign wanted[i]     = excFlags[i] & instTrapEn[i];
    assign suppressed[i] = wanted[i] & swComp & disBits[i];
    assign resTrap[i]    = wanted[i] & ~suppressed[i];
  end

  always_comb begin
    inputTrap  = instValid & excFlags[IDX_DEN] & ~dnzBit;
    resultTrap = instValid & (|resTrap) & ~inputTrap;
    trapReq    = inputTrap | resultTrap;
    defaultSel = instValid & ~trapReq & (|suppressed);
    flushZero  = instValid & excFlags[IDX_UF] & ~trapReq;
    cfgError   = disBits[IDX_UF] & ~undzBit;
    trapBits   = '0;
    if (inputTrap)       trapBits[IDX_DEN]     = 1'b1;
    else if (resultTrap) trapBits[RES_NUM-1:0] = resTrap;
    strobes.csrWrite  = csrWrEn;
    strobes.excRecord = instValid & (|excFlags);
    strobes.sumLoad   = trapReq;
    strobes.sumClear  = summaryAck & ~trapReq;
  end

  AST_TRAP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (trapReq || defaultSel || flushZero) |-> instValid); // R10
  AST_TRAP_XOR_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(trapReq && defaultSel)); // R4
  AST_DISABLE_NEEDS_SW: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && !swComp && |(excFlags[RES_NUM-1:0] & instTrapEn)) |-> trapReq); // R4
endmodule

// File: rtl/fp_exc_dp.sv
`timescale 1ns/1ps
module fp_exc_dp
  import fp_exc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctlStrobes_t        strobes,
  input  logic [CSR_W-1:0]   csrWrData,
  input  logic [EXC_NUM-1:0] excFlags,
  input  logic [EXC_NUM-1:0] trapBits,
  output logic [CSR_W-1:0]   csrValue,
  output logic [EXC_NUM-1:0] excSummary,
  output logic               summaryValid
);
  logic [CSR_W-1:0] csrReg, csrNext;

  always_comb begin
    csrNext = strobes.csrWrite ? csrWrData : csrReg;
    if (strobes.excRecord)
      csrNext[EXC_NUM-1:0] = csrNext[EXC_NUM-1:0] | excFlags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csrReg       <= '0;
      excSummary   <= '0;
      summaryValid <= 1'b0;
    end else begin
      csrReg <= csrNext;
      if (strobes.sumLoad) begin
        excSummary   <= trapBits;
        summaryValid <= 1'b1;
      end else if (strobes.sumClear) begin
        excSummary   <= '0;
        summaryValid <= 1'b0;
      end
    end
  end

  assign csrValue = csrReg;

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.csrWrite |=> (($past(csrReg[EXC_NUM-1:0]) & ~csrReg[EXC_NUM-1:0]) == '0)); // R2
  AST_STATUS_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.excRecord |=> ((csrReg[EXC_NUM-1:0] & $past(excFlags)) == $past(excFlags))); // R1
  AST_SUMMARY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (summaryValid && !strobes.sumLoad && !strobes.sumClear) |=> (summaryValid && $stable(excSummary))); // R7
endmodule

// File: rtl/fp_exc_trap_ctl.sv
`timescale 1ns/1ps
module fp_exc_trap_ctl
  import fp_exc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instValid,
  input  logic [EXC_NUM-1:0] excFlags,
  input  logic [RES_NUM-1:0] instTrapEn,
  input  logic               swComp,
  input  logic               csrWrEn,
  input  logic [CSR_W-1:0]   csrWrData,
  input  logic               summaryAck,
  output logic [CSR_W-1:0]   csrValue,
  output logic [EXC_NUM-1:0] excSummary,
  output logic               summaryValid,
  output logic               trapReq,
  output logic               defaultSel,
  output logic               flushZero,
  output logic               cfgError
);
  ctlStrobes_t        strobes;
  logic [EXC_NUM-1:0] trapBits;

  fp_exc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .instValid  (instValid),
    .excFlags   (excFlags),
    .instTrapEn (instTrapEn),
    .swComp     (swComp),
    .csrWrEn    (csrWrEn),
    .summaryAck (summaryAck),
    .disBits    (csrValue[DIS_LO +: RES_NUM]),
    .undzBit    (csrValue[UNDZ_POS]),
    .dnzBit     (csrValue[DNZ_POS]),
    .trapReq    (trapReq),
    .defaultSel (defaultSel),
    .flushZero  (flushZero),
    .cfgError   (cfgError),
    .trapBits   (trapBits),
    .strobes    (strobes)
  );

  fp_exc_dp u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .csrWrData    (csrWrData),
    .excFlags     (excFlags),
    .trapBits     (trapBits),
    .csrValue     (csrValue),
    .excSummary   (excSummary),
    .summaryValid (summaryValid)
  );

  AST_INPUT_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && excFlags[IDX_DEN] && !csrValue[DNZ_POS]) |=>
      (excSummary == EXC_NUM'(1) << IDX_DEN)); // R6
  AST_DNZ_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && csrValue[DNZ_POS] && excFlags[RES_NUM-1:0] == '0) |-> !trapReq); // R5
endmodule

// File: tb/fp_exc_trap_ctl_bench.sv
`timescale 1ns/1ps
module fp_exc_trap_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instValid, swComp, csrWrEn, summaryAck;
  logic [5:0]  excFlags;
  logic [4:0]  instTrapEn;
  logic [12:0] csrWrData;
  logic [12:0] csrValue;
  logic [5:0]  excSummary;
  logic        summaryValid, trapReq, defaultSel, flushZero, cfgError;
  int          nChecks = 0;
  int          nFails = 0;

  always #2.5 clk = ~clk;

  fp_exc_trap_ctl u_fp_exc_trap_ctl (
    .clk(clk), .rst_n(rst_n), .instValid(instValid), .excFlags(excFlags),
    .instTrapEn(instTrapEn), .swComp(swComp), .csrWrEn(csrWrEn),
    .csrWrData(csrWrData), .summaryAck(summaryAck), .csrValue(csrValue),
    .excSummary(excSummary), .summaryValid(summaryValid), .trapReq(trapReq),
    .defaultSel(defaultSel), .flushZero(flushZero), .cfgError(cfgError));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [12:0] word(input logic dnz, input logic undz,
                                       input logic [4:0] dis, input logic [5:0] st);
    return {dnz, undz, dis, st};
  endfunction

  task automatic idle();
    instValid = 0; csrWrEn = 0; summaryAck = 0; swComp = 0;
    excFlags = '0; instTrapEn = '0; csrWrData = '0;
  endtask

  initial begin
    #(5.0 * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check("R2 reset csr", csrValue, 0);
    check("R7 reset summaryValid", summaryValid, 0);
    check("R3 reset trapReq", trapReq, 0);

    // Sweep: flags x enables x qualifier x denormal control
    for (int f = 0; f < 64; f++)
      for (int e = 0; e < 32; e++)
        for (int s = 0; s < 2; s++)
          for (int z = 0; z < 2; z++) begin
            logic [5:0] fl;
            logic [4:0] en, d, want, sup, res;
            logic inT, resT, trap, def, fz;
            logic [5:0] sum;
            fl = 6'(f); en = 5'(e); d = 5'((f * 5 + e * 3 + s + z) & 31);
            want = fl[4:0] & en;
            sup  = want & {5{s[0]}} & d;
            res  = want & ~sup;
            inT  = fl[5] & ~z[0];
            resT = (|res) & ~inT;
            trap = inT | resT;
            sum  = inT ? 6'b100000 : (resT ? {1'b0, res} : 6'b0);
            def  = ~trap & (|sup);
            fz   = fl[3] & ~trap;
            @(negedge clk);
            idle();
            csrWrEn = 1; csrWrData = word(z[0], 1'b1, d, 6'b0); summaryAck = 1;
            @(negedge clk);
            idle();
            instValid = 1; excFlags = fl; instTrapEn = en; swComp = s[0];
            #1;
            check("R3/R5 trapReq", trapReq, trap);
            check("R4 defaultSel", defaultSel, def);
            check("R8 flushZero", flushZero, fz);
            @(negedge clk);
            idle();
            #1;
            check("R1 status", csrValue[5:0], fl);
            check("R3 summaryValid", summaryValid, trap);
            check("R6 excSummary", excSummary, sum);
            check("R10 no trap when idle", trapReq, 0);
          end

    // R2: sticky across instructions, then write plus exception in one cycle
    @(negedge clk); idle(); csrWrEn = 1; csrWrData = word(1'b1, 1'b1, 5'b0, 6'b0); summaryAck = 1;
    @(negedge clk); idle(); instValid = 1; excFlags = 6'b000010;
    @(negedge clk); idle(); instValid = 1; excFlags = 6'b000100;
    #1; check("R1 status accumulates pending", csrValue[5:0], 6'b000010);
    @(negedge clk); idle(); #1;
    check("R2 sticky accumulate", csrValue[5:0], 6'b000110);
    instValid = 1; excFlags = 6'b001000; csrWrEn = 1;
    csrWrData = word(1'b1, 1'b1, 5'b0, 6'b000001);
    @(negedge clk); idle(); #1;
    check("R2 write then OR", csrValue[5:0], 6'b001001);
    // R10: flags without valid
    excFlags = 6'b111111; instTrapEn = 5'b11111;
    #1;
    check("R10 trapReq", trapReq, 0);
    check("R10 defaultSel", defaultSel, 0);
    check("R10 flushZero", flushZero, 0);
    @(negedge clk); #1;
    check("R10 status unchanged", csrValue[5:0], 6'b001001);

    // R7: hold, ack with simultaneous trap, plain ack
    @(negedge clk); idle(); csrWrEn = 1; csrWrData = word(1'b0, 1'b1, 5'b0, 6'b0);
    @(negedge clk); idle(); instValid = 1; excFlags = 6'b000001; instTrapEn = 5'b00001;
    @(negedge clk); idle();
    @(negedge clk); idle(); #1;
    check("R7 hold valid", summaryValid, 1);
    check("R7 hold value", excSummary, 6'b000001);
    instValid = 1; excFlags = 6'b000100; instTrapEn = 5'b00100; summaryAck = 1;
    @(negedge clk); idle(); #1;
    check("R7 trap beats ack", excSummary, 6'b000100);
    check("R7 trap beats ack valid", summaryValid, 1);
    summaryAck = 1;
    @(negedge clk); idle(); #1;
    check("R7 ack clears valid", summaryValid, 0);
    check("R7 ack clears value", excSummary, 0);

    // R9: configuration error
    csrWrEn = 1; csrWrData = word(1'b0, 1'b0, 5'b01000, 6'b0);
    @(negedge clk); idle(); #1;
    check("R9 cfgError set", cfgError, 1);
    csrWrEn = 1; csrWrData = word(1'b0, 1'b1, 5'b01000, 6'b0);
    @(negedge clk); idle(); #1;
    check("R9 cfgError clear", cfgError, 0);
    csrWrEn = 1; csrWrData = word(1'b0, 1'b0, 5'b10111, 6'b0);
    @(negedge clk); idle(); #1;
    check("R9 other disables no error", cfgError, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule